// File: doc/BRIEF.md
# Task Context Store Sequencer

This block saves the context of a running task into memory as a burst of 32-bit words. A start strobe latches the task base address, the task control word, the stack-pointer enable bits taken from the system control word, and a mask that picks which general registers to save. The sequencer then writes the selected words one at a time to word-aligned addresses that climb by 4 from the base. Each write waits for the memory to accept it.

The order of the words is fixed. The task control word comes first. Next come the stack pointers of privilege levels 0 to 3, in level order, each one only if its enable bit is set. Last come the general registers, lowest index first, each one only if its mask bit is set. One cycle after the start, the block asks for status-word bit 28 to be set and asks for the current stack pointer to be copied into its level slot. Both requests come before any memory write. A one-cycle done pulse closes the operation.

Top module: `task_ctx_store`

## Requirements
- R1: The first write goes to `task_base_i`. Each accepted write (`mem_wvalid_o` and `mem_wready_i` high at a clock edge) moves the address of the next write up by exactly 4.
- R2: The first word written in every operation is `task_ctl_i`.
- R3: After the control word come the stack pointers of levels 0, 1, 2 and 3, in that order. The pointer of level L is written only if `sys_ctl_i` bit 8+L is set. Its value is `lvl_sp_i[32*L +: 32]`.
- R4: After the stack pointers come the general registers 0 to 30, in ascending order. Register i is written only if `reg_mask_i` bit i is set. While register i is being written, `reg_idx_o` equals i and the word written is `reg_rdata_i` from that same cycle.
- R5: In the cycle after a start is taken, `flag_set_o` (a request to set status bit 28) and `sp_save_o` (a request to copy the current stack pointer into its level slot) are both high for exactly one cycle, and no write is offered in that cycle.
- R6: While a write is offered and `mem_wready_i` is low, `mem_wvalid_o` stays high and the address and data stay unchanged.
- R7: `done_o` is high for exactly one cycle, in the cycle right after the last write is accepted. It is high once per operation.
- R8: A start strobe is ignored while an operation is in progress. No new request pulse appears and no extra word is written.
- R9: In reset, and after reset until a start arrives, no write is offered and `done_o`, `flag_set_o` and `sp_save_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| start_i | input | 1 | Start strobe, taken only while idle |
| task_base_i | input | 32 | Base address of the save area |
| task_ctl_i | input | 32 | Task control word, always written first |
| sys_ctl_i | input | 32 | System control word; bits 8 to 11 enable the four stack-pointer saves |
| lvl_sp_i | input | 128 | Stack pointers of levels 0 to 3, 32 bits each, level 0 in the low bits |
| reg_mask_i | input | 31 | One bit per general register to save |
| reg_rdata_i | input | 32 | Register file read data for `reg_idx_o`, available in the same cycle |
| reg_idx_o | output | 5 | Index of the register being read |
| mem_wvalid_o | output | 1 | A write is offered |
| mem_wready_i | input | 1 | Memory accepts the offered write |
| mem_waddr_o | output | 32 | Write address |
| mem_wdata_o | output | 32 | Write data |
| flag_set_o | output | 1 | Request to set status-word bit 28 |
| sp_save_o | output | 1 | Request to copy the current stack pointer into its level slot |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
The checks on the first word and the first address assume that `task_base_i`, `task_ctl_i` and `lvl_sp_i` do not change from the start strobe until done. They also assume that `reg_rdata_i` depends only on `reg_idx_o`. The bench follows both rules. It changes its operation inputs only while the block is idle, and it forms the register data as an arithmetic function of the index. The only inputs that change during an operation are the ready line, which stalls writes in a pseudo-random pattern, and repeated start strobes that the block must ignore.

// File: rtl/tcs_pkg.sv
package tcs_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_PREP  = 2'd1,
    ST_WRITE = 2'd2,
    ST_DONE  = 2'd3
  } tcs_state_e;
endpackage

// File: rtl/tcs_pick.sv
// Finds the lowest pending item: its index and a one-hot mask of it.
module tcs_pick #(
  parameter int unsigned N  = 36,
  localparam int unsigned IW = $clog2(N)
) (
  input  logic [N-1:0]  pend_i,
  output logic [IW-1:0] idx_o,
  output logic [N-1:0]  onehot_o
);
  always_comb begin
    idx_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (pend_i[i]) idx_o = IW'(i);
    end
  end

  assign onehot_o = pend_i & (~pend_i + N'(1));
endmodule

// File: rtl/tcs_addr_ctr.sv
// Address counter: loads the base address and steps by one word.
module tcs_addr_ctr #(
  parameter int unsigned AW   = 32,
  parameter int unsigned STEP = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_i,
  input  logic [AW-1:0] base_i,
  input  logic          step_i,
  output logic [AW-1:0] addr_o
);
  logic [AW-1:0] addr_d;
  logic          addr_en;

  assign addr_en = load_i | step_i;

  always_comb begin
    addr_d = addr_o;
    if (load_i)      addr_d = base_i;
    else if (step_i) addr_d = addr_o + AW'(STEP);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       addr_o <= '0;
    else if (addr_en) addr_o <= addr_d;
  end
endmodule

// File: rtl/tcs_word_mux.sv
// Chooses the word for the current item: control word, a stack pointer or a register.
module tcs_word_mux #(
  parameter int unsigned DW   = 32,
  parameter int unsigned NSP  = 4,
  parameter int unsigned NREG = 31,
  localparam int unsigned NITEM = 1 + NSP + NREG,
  localparam int unsigned IW    = $clog2(NITEM),
  localparam int unsigned RIW   = $clog2(NREG),
  localparam int unsigned SPW   = (NSP > 1) ? $clog2(NSP) : 1
) (
  input  logic [IW-1:0]     item_i,
  input  logic [DW-1:0]     tcw_i,
  input  logic [NSP*DW-1:0] sp_i,
  input  logic [DW-1:0]     reg_rdata_i,
  output logic [RIW-1:0]    reg_idx_o,
  output logic [DW-1:0]     wdata_o
);
  localparam logic [IW-1:0] SP_FIRST  = IW'(1);
  localparam logic [IW-1:0] REG_FIRST = IW'(1 + NSP);

  logic [DW-1:0]  sp_arr [NSP];
  logic           is_tcw;
  logic           is_reg;
  logic [SPW-1:0] sp_sel;

  for (genvar g = 0; g < NSP; g++) begin : g_sp
    assign sp_arr[g] = sp_i[g*DW +: DW];
  end

  assign is_tcw    = (item_i == '0);
  assign is_reg    = (item_i >= REG_FIRST);
  assign sp_sel    = SPW'(item_i - SP_FIRST);
  assign reg_idx_o = is_reg ? RIW'(item_i - REG_FIRST) : '0;

  always_comb begin
    if (is_tcw)      wdata_o = tcw_i;
    else if (is_reg) wdata_o = reg_rdata_i;
    else             wdata_o = sp_arr[sp_sel];
  end
endmodule

// File: rtl/task_ctx_store.sv
module task_ctx_store #(
  parameter int unsigned DW       = 32,
  parameter int unsigned AW       = 32,
  parameter int unsigned SCW      = 32,
  parameter int unsigned NSP      = 4,
  parameter int unsigned NREG     = 31,
  parameter int unsigned SPEN_LSB = 8,
  localparam int unsigned NITEM = 1 + NSP + NREG,
  localparam int unsigned IW    = $clog2(NITEM),
  localparam int unsigned RIW   = $clog2(NREG)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [AW-1:0]     task_base_i,
  input  logic [DW-1:0]     task_ctl_i,
  input  logic [SCW-1:0]    sys_ctl_i,
  input  logic [NSP*DW-1:0] lvl_sp_i,
  input  logic [NREG-1:0]   reg_mask_i,
  input  logic [DW-1:0]     reg_rdata_i,
  output logic [RIW-1:0]    reg_idx_o,
  output logic              mem_wvalid_o,
  input  logic              mem_wready_i,
  output logic [AW-1:0]     mem_waddr_o,
  output logic [DW-1:0]     mem_wdata_o,
  output logic              flag_set_o,
  output logic              sp_save_o,
  output logic              done_o
);
  import tcs_pkg::*;

  // reset: asynchronous assert, synchronous release
  logic [1:0] rst_sync_q;
  logic       rst_n_int;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_int = rst_sync_q[1];

  // only the enable field of the system control word is used
  logic unused_scw;
  assign unused_scw = ^sys_ctl_i;

  tcs_state_e       state_q, state_d;
  logic [NITEM-1:0] pend_q, pend_d, pick_oh, pend_rest;
  logic [IW-1:0]    pick_idx;
  logic [DW-1:0]    tcw_q;
  logic             start_ok, accept, last, pend_en, state_en;

  assign start_ok  = start_i && (state_q == ST_IDLE);
  assign accept    = (state_q == ST_WRITE) && mem_wready_i;
  assign pend_rest = pend_q & ~pick_oh;
  assign last      = (pend_rest == '0);
  assign pend_en   = start_ok | accept;
  assign state_en  = (state_d != state_q);

  tcs_pick #(.N(NITEM)) pick_i (
    .pend_i   (pend_q),
    .idx_o    (pick_idx),
    .onehot_o (pick_oh)
  );

  tcs_addr_ctr #(.AW(AW), .STEP(DW / 8)) addr_i (
    .clk    (clk),
    .rst_n  (rst_n_int),
    .load_i (start_ok),
    .base_i (task_base_i),
    .step_i (accept),
    .addr_o (mem_waddr_o)
  );

  tcs_word_mux #(.DW(DW), .NSP(NSP), .NREG(NREG)) mux_i (
    .item_i      (pick_idx),
    .tcw_i       (tcw_q),
    .sp_i        (lvl_sp_i),
    .reg_rdata_i (reg_rdata_i),
    .reg_idx_o   (reg_idx_o),
    .wdata_o     (mem_wdata_o)
  );

  always_comb begin
    pend_d = pend_q;
    if (start_ok)    pend_d = {reg_mask_i, sys_ctl_i[SPEN_LSB +: NSP], 1'b1};
    else if (accept) pend_d = pend_rest;
  end

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:  if (start_ok) state_d = ST_PREP;
      ST_PREP:  state_d = ST_WRITE;
      ST_WRITE: if (accept && last) state_d = ST_DONE;
      ST_DONE:  state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n_int) begin
    if (!rst_n_int)    state_q <= ST_IDLE;
    else if (state_en) state_q <= state_d;
  end

  always_ff @(posedge clk or negedge rst_n_int) begin
    if (!rst_n_int)   pend_q <= '0;
    else if (pend_en) pend_q <= pend_d;
  end

  always_ff @(posedge clk or negedge rst_n_int) begin
    if (!rst_n_int)    tcw_q <= '0;
    else if (start_ok) tcw_q <= task_ctl_i;
  end

  assign mem_wvalid_o = (state_q == ST_WRITE);
  assign flag_set_o   = (state_q == ST_PREP);
  assign sp_save_o    = (state_q == ST_PREP);
  assign done_o       = (state_q == ST_DONE);
endmodule

// File: rtl/task_ctx_store_chk.sv
module task_ctx_store_chk #(
  parameter int unsigned DW   = 32,
  parameter int unsigned AW   = 32,
  parameter int unsigned NREG = 31,
  localparam int unsigned RIW = $clog2(NREG)
) (
  input logic           clk,
  input logic           rst_n,
  input logic [AW-1:0]  task_base_i,
  input logic [DW-1:0]  task_ctl_i,
  input logic [RIW-1:0] reg_idx_o,
  input logic           mem_wvalid_o,
  input logic           mem_wready_i,
  input logic [AW-1:0]  mem_waddr_o,
  input logic [DW-1:0]  mem_wdata_o,
  input logic           flag_set_o,
  input logic           sp_save_o,
  input logic           done_o
);
  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_wvalid_o && mem_wready_i) |=>
      (!mem_wvalid_o || mem_waddr_o == $past(mem_waddr_o) + AW'(4))); // R1

  AST_FIRST_WORD: assert property (@(posedge clk) disable iff (!rst_n)
    flag_set_o |=> (mem_wvalid_o && mem_wdata_o == task_ctl_i &&
                    mem_waddr_o == task_base_i)); // R2

  AST_REG_IDX_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wvalid_o |-> (int'(reg_idx_o) < NREG)); // R4

  AST_PREP_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    flag_set_o |-> (sp_save_o && !mem_wvalid_o && !done_o)); // R5

  AST_PREP_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    flag_set_o |=> !flag_set_o); // R5

  AST_HOLD_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_wvalid_o && !mem_wready_i) |=> (mem_wvalid_o && $stable(mem_waddr_o))); // R6

  AST_DONE_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (!mem_wvalid_o && $past(mem_wvalid_o && mem_wready_i))); // R7

  AST_NO_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_wvalid_o || done_o) |=> !flag_set_o); // R8
endmodule

bind task_ctx_store task_ctx_store_chk #(.DW(DW), .AW(AW), .NREG(NREG)) chk_i (
  .clk          (clk),
  .rst_n        (rst_n),
  .task_base_i  (task_base_i),
  .task_ctl_i   (task_ctl_i),
  .reg_idx_o    (reg_idx_o),
  .mem_wvalid_o (mem_wvalid_o),
  .mem_wready_i (mem_wready_i),
  .mem_waddr_o  (mem_waddr_o),
  .mem_wdata_o  (mem_wdata_o),
  .flag_set_o   (flag_set_o),
  .sp_save_o    (sp_save_o),
  .done_o       (done_o)
);

// File: tb/task_ctx_store_tb.sv
module task_ctx_store_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int MAXW       = 64;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         start_i;
  logic [31:0]  task_base_i, task_ctl_i, sys_ctl_i, reg_rdata_i, mem_waddr_o, mem_wdata_o;
  logic [127:0] lvl_sp_i;
  logic [30:0]  reg_mask_i;
  logic [4:0]   reg_idx_o;
  logic         mem_wvalid_o, mem_wready_i, flag_set_o, sp_save_o, done_o;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;

  // log of writes for the current operation
  logic [31:0] log_addr [MAXW];
  logic [31:0] log_data [MAXW];
  int n_wr = 0, n_flag = 0, n_spsv = 0, n_done = 0, since_wr = 100;
  logic        prev_stall = 1'b0;
  logic [31:0] prev_addr  = '0;
  logic [7:0]  lfsr = 8'h5A;

  always #(CLK_PERIOD / 2) clk = ~clk;

  assign reg_rdata_i = 32'hC000_0000 + 32'(reg_idx_o) * 32'h0001_0101;

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task_ctx_store dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .task_base_i(task_base_i),
    .task_ctl_i(task_ctl_i), .sys_ctl_i(sys_ctl_i), .lvl_sp_i(lvl_sp_i),
    .reg_mask_i(reg_mask_i), .reg_rdata_i(reg_rdata_i), .reg_idx_o(reg_idx_o),
    .mem_wvalid_o(mem_wvalid_o), .mem_wready_i(mem_wready_i),
    .mem_waddr_o(mem_waddr_o), .mem_wdata_o(mem_wdata_o),
    .flag_set_o(flag_set_o), .sp_save_o(sp_save_o), .done_o(done_o)
  );

  // memory model and monitor, all at the falling edge
  always @(negedge clk) begin
    cycles++;
    lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    mem_wready_i = lfsr[0] | lfsr[2];
    if (rst_n) begin
      since_wr++;
      if (prev_stall) begin
        check(mem_wvalid_o === 1'b1, "R6 valid held", 32'(mem_wvalid_o), 32'd1);
        check(mem_waddr_o === prev_addr, "R6 address held", mem_waddr_o, prev_addr);
      end
      if (flag_set_o) n_flag++;
      if (sp_save_o)  n_spsv++;
      if (done_o) begin
        n_done++;
        check(since_wr == 1, "R7 done right after last write", 32'(since_wr), 32'd1);
      end
      if (mem_wvalid_o && mem_wready_i) begin
        if (n_wr < MAXW) begin
          log_addr[n_wr] = mem_waddr_o;
          log_data[n_wr] = mem_wdata_o;
        end
        n_wr++;
        since_wr = 0;
      end
      prev_stall = mem_wvalid_o && !mem_wready_i;
      prev_addr  = mem_waddr_o;
    end
  end

  // watchdog
  initial begin
    wait (cycles > 150000);
    fails++;
    $display("FAIL watchdog actual=%0d expected=<150000", cycles);
    $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  task automatic run_op(input int op, input logic [3:0] en, input logic [30:0] mask, input bit poke);
    logic [31:0] ea [MAXW];
    logic [31:0] ed [MAXW];
    string       er [MAXW];
    int          ne = 0;
    int          t  = 0;
    @(negedge clk);
    task_base_i = 32'h0001_0000 + 32'(op) * 32'h100;
    task_ctl_i  = 32'h7C00_0000 + 32'(op);
    sys_ctl_i   = {20'hABCDE, en, 8'h3C};
    for (int l = 0; l < 4; l++) lvl_sp_i[32*l +: 32] = 32'h5000_0000 + 32'(l) * 32'h1110 + 32'(op);
    reg_mask_i  = mask;
    n_wr = 0; n_flag = 0; n_spsv = 0; n_done = 0;
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    if (poke) begin
      repeat (3) @(negedge clk);
      start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
    end
    while (n_done == 0 && t < 400) begin
      @(negedge clk);
      t++;
    end
    repeat (3) @(negedge clk);
    // expected sequence
    ea[ne] = task_base_i; ed[ne] = task_ctl_i; er[ne] = "R2 control word"; ne++;
    for (int l = 0; l < 4; l++)
      if (en[l]) begin
        ed[ne] = lvl_sp_i[32*l +: 32]; er[ne] = "R3 stack pointer"; ne++;
      end
    for (int r = 0; r < 31; r++)
      if (mask[r]) begin
        ed[ne] = 32'hC000_0000 + 32'(r) * 32'h0001_0101; er[ne] = "R4 register"; ne++;
      end
    for (int k = 0; k < ne; k++) ea[k] = task_base_i + 32'(k) * 32'd4;
    check(n_wr == ne, poke ? "R8 word count with extra start" : "R3 R4 word count", 32'(n_wr), 32'(ne));
    for (int k = 0; k < ne && k < n_wr; k++) begin
      check(log_addr[k] === ea[k], "R1 address", log_addr[k], ea[k]);
      check(log_data[k] === ed[k], er[k], log_data[k], ed[k]);
    end
    check(n_flag == 1, poke ? "R8 one flag request" : "R5 flag request", 32'(n_flag), 32'd1);
    check(n_spsv == 1, "R5 stack save request", 32'(n_spsv), 32'd1);
    check(n_done == 1, "R7 one done pulse", 32'(n_done), 32'd1);
  endtask

  initial begin
    logic [30:0] masks [6];
    rst_n = 1'b0; start_i = 1'b0; mem_wready_i = 1'b0;
    task_base_i = '0; task_ctl_i = '0; sys_ctl_i = '0; lvl_sp_i = '0; reg_mask_i = '0;
    repeat (3) @(negedge clk);
    check(mem_wvalid_o === 1'b0, "R9 no write in reset", 32'(mem_wvalid_o), 32'd0);
    check(done_o === 1'b0, "R9 no done in reset", 32'(done_o), 32'd0);
    check(flag_set_o === 1'b0, "R9 no flag in reset", 32'(flag_set_o), 32'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(mem_wvalid_o === 1'b0 && done_o === 1'b0 && sp_save_o === 1'b0,
          "R9 quiet after reset", {29'd0, mem_wvalid_o, done_o, sp_save_o}, 32'd0);
    masks[0] = 31'h0;
    masks[1] = 31'h7FFF_FFFF;
    masks[2] = 31'h0000_0001;
    masks[3] = 31'h4000_0000;
    masks[4] = 31'h5555_5555;
    masks[5] = 31'h0F0F_3C3C;
    for (int en = 0; en < 16; en++)
      for (int m = 0; m < 6; m++)
        run_op(en * 6 + m, 4'(en), masks[m] ^ (m == 5 ? 31'(en * 32'h0101_0101) : 31'h0), (m == 4));
    $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule